// File: doc/BRIEF.md
# Disk Motor Monoflop and Bus Wait-State Generator

This block sits beside a floppy disk controller chip on a CPU expansion card. It does two jobs. First, it keeps the drive motor enable line high for a fixed number of clock cycles after software writes a rising value to a motor strobe bit. Every new rising write starts the full interval again. Second, it holds the CPU bus READY line low while the CPU reads from the controller chip and waits for a data byte. This inserts wait states until the chip raises its data request or interrupt line.

The wait path only acts while the motor enable is high. If no disk is present, the data request never comes, but the wait still ends when the motor interval runs out. READY is formed combinationally from the registered motor state, the registered wait-enable bit and the live select, DRQ and INTRQ inputs. It therefore follows those inputs in the same cycle.

Top module: `fdm_motor_wait`

## Requirements
- R1: On a cycle with `mot_wr`=1, the block stores `mot_bit` as the last strobe value. The motor interval is triggered only when `mot_bit`=1 and the stored value was 0. Writing 1 while the stored value is already 1 does not restart the interval.
- R2: After the clock edge that samples a trigger, `motor_en` is 1 for exactly `ON_CYCLES` consecutive cycles and then returns to 0.
- R3: A trigger while `motor_en` is already 1 restarts the full `ON_CYCLES` interval from that edge.
- R4: A write of `mot_bit`=0 does not shorten or stop a running motor interval.
- R5: `ready` is 0 exactly when all of these hold: `ctl_sel`=1, the stored wait enable is 1, `drq`=0, `intrq`=0 and `motor_en`=1. Otherwise `ready` is 1.
- R6: `ready` responds in the same cycle to a change on `ctl_sel`, `drq` or `intrq`. It also returns to 1 in the same cycle that `motor_en` falls at the end of the interval.
- R7: The wait enable loads `wen_bit` on a cycle with `wen_wr`=1 and holds its value on every other cycle.
- R8: A synchronous active-low reset clears the motor enable, the stored last strobe value and the wait enable. After reset, `ready` is 1 and the next write of 1 to `mot_bit` triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mot_wr | input | 1 | Write strobe for the motor bit |
| mot_bit | input | 1 | Value written to the motor bit |
| wen_wr | input | 1 | Write strobe for the wait-enable bit |
| wen_bit | input | 1 | Value written to the wait-enable bit |
| ctl_sel | input | 1 | Address decoder says the controller chip is being accessed |
| drq | input | 1 | Data request from the controller chip, active high |
| intrq | input | 1 | Interrupt request from the controller chip, active high |
| motor_en | output | 1 | Drive motor enable |
| ready | output | 1 | Bus READY, active high; 0 inserts wait states |

## Verification
Register writes to the motor and wait-enable bits take effect one edge after they are sampled. `ready` is combinational, so a change on select, DRQ or INTRQ shows up in the same cycle. The bench drives inputs shortly after the rising edge and compares both outputs at the falling edge against a behavioural model. That model updates its counter and flags on the rising edge. The bench counts the pulse length at falling edges, starting in the first cycle after the trigger edge, so all `ON_CYCLES` high cycles are counted. It also samples `ready` in the cycle where the motor drops, to check the timeout release.

// File: rtl/fdm_pkg.sv
// Package: shared types for the disk motor / wait-state block.
// Assumes nothing beyond a single clock domain.
package fdm_pkg;

    // Conditions that together request a bus wait state
    typedef struct packed {
        logic sel;     // controller chip addressed
        logic wen;     // wait generation armed
        logic drq;     // data request pending
        logic intrq;   // interrupt pending
        logic motor;   // motor interval running
    } fdm_wait_cond_t;

    // Counter width able to hold the value n
    function automatic int fdm_cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fdm_strobe_edge.sv
// Module: fdm_strobe_edge
// Stores the last value written to the motor bit and flags a trigger
// when a 1 is written while the stored value is 0.
// Assumes wr is a single-cycle write strobe in the clk domain.
module fdm_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic bit_in,
    output logic trig
);

    logic last_q;

    // Remember the previously written strobe value
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else if (wr)
            last_q <= bit_in;
    end

    // Trigger only on a 0 -> 1 transition of the written value
    always_comb trig = wr & bit_in & ~last_q;

    // R1: the stored value follows every write
    a_r1_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (last_q == $past(bit_in)));

    // R1: two consecutive writes of 1 trigger at most once
    a_r1_no_double_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bit_in) |=> !(wr && bit_in && trig));

endmodule

// File: rtl/fdm_monoflop.sv
// Module: fdm_monoflop
// Retriggerable down-counter holding motor_on high for ON_CYCLES
// cycles after the edge that samples trig.
// Assumes ON_CYCLES >= 1.
module fdm_monoflop #(
    parameter int ON_CYCLES = 4_230_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic motor_on
);
    import fdm_pkg::*;

    localparam int CW = fdm_cnt_w(ON_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(ON_CYCLES);

    logic [CW-1:0] cnt_q;

    // Reload on trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (trig)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    // Motor runs while the counter is nonzero
    always_comb motor_on = (cnt_q != '0);

    // R2: a trigger turns the motor on at the next edge
    a_r2_trig_starts: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> motor_on);

    // R3: a trigger restarts from the full count
    a_r3_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt_q == LOAD));

    // R2: last count cycle without trigger ends the interval
    a_r2_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(1) && !trig) |=> !motor_on);

    // R4: without a trigger a running motor only counts down by one
    a_r4_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_on && !trig) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/fdm_ready_gen.sv
// Module: fdm_ready_gen
// Holds the wait-enable bit and forms bus READY from the wait
// conditions. READY is combinational from registered state and live
// inputs. Assumes drq/intrq are synchronous to clk.
module fdm_ready_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic wen_wr,
    input  logic wen_bit,
    input  logic ctl_sel,
    input  logic drq,
    input  logic intrq,
    input  logic motor_on,
    output logic ready
);
    import fdm_pkg::*;

    logic           wen_q;
    fdm_wait_cond_t cond;

    // Wait-enable register, written by its own strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            wen_q <= 1'b0;
        else if (wen_wr)
            wen_q <= wen_bit;
    end

    // Gather the conditions and release READY unless all call for a wait
    always_comb begin
        cond.sel   = ctl_sel;
        cond.wen   = wen_q;
        cond.drq   = drq;
        cond.intrq = intrq;
        cond.motor = motor_on;
        ready = ~(cond.sel & cond.wen & ~cond.drq & ~cond.intrq & cond.motor);
    end

    // R5: any pending data request releases the bus
    a_r5_drq_release: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> ready);

    // R5: any pending interrupt releases the bus
    a_r5_intrq_release: assert property (@(posedge clk) disable iff (!rst_n)
        intrq |-> ready);

    // R6: a stopped motor never stalls the bus
    a_r6_motor_release: assert property (@(posedge clk) disable iff (!rst_n)
        !motor_on |-> ready);

    // R7: the wait enable holds without a write
    a_r7_wen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_wr |=> $stable(wen_q));

endmodule

// File: rtl/fdm_motor_wait.sv
// Module: fdm_motor_wait (top)
// Drive motor monoflop plus bus wait-state generator for a disk
// controller card. Assumes all inputs are synchronous to clk and that
// ON_CYCLES is the motor on-time expressed in clock cycles.
module fdm_motor_wait #(
    parameter int ON_CYCLES = 4_230_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mot_wr,
    input  logic mot_bit,
    input  logic wen_wr,
    input  logic wen_bit,
    input  logic ctl_sel,
    input  logic drq,
    input  logic intrq,
    output logic motor_en,
    output logic ready
);

    logic trig;

    // Rising-edge detector on the written motor bit
    fdm_strobe_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (mot_wr),
        .bit_in (mot_bit),
        .trig   (trig)
    );

    // Retriggerable on-time counter
    fdm_monoflop #(.ON_CYCLES(ON_CYCLES)) i_mono (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .motor_on (motor_en)
    );

    // Wait-enable register and READY gating
    fdm_ready_gen i_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .wen_wr   (wen_wr),
        .wen_bit  (wen_bit),
        .ctl_sel  (ctl_sel),
        .drq      (drq),
        .intrq    (intrq),
        .motor_on (motor_en),
        .ready    (ready)
    );

    // R8: reset leaves the motor off and the bus released
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!motor_en && ready));

endmodule

// File: tb/test_fdm_motor_wait.sv
module test_fdm_motor_wait;

    localparam int CLK_PERIOD = 10;
    localparam int ON = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mot_wr = 0, mot_bit = 0, wen_wr = 0, wen_bit = 0;
    logic ctl_sel = 0, drq = 0, intrq = 0;
    logic motor_en, ready;

    int n_tests = 0;
    int n_fail = 0;
    bit started = 0;

    // reference model state
    int  m_cnt = 0;
    bit  m_last = 0;
    bit  m_wen = 0;

    fdm_motor_wait #(.ON_CYCLES(ON)) i_fdm_motor_wait (
        .clk(clk), .rst_n(rst_n), .mot_wr(mot_wr), .mot_bit(mot_bit),
        .wen_wr(wen_wr), .wen_bit(wen_bit), .ctl_sel(ctl_sel),
        .drq(drq), .intrq(intrq), .motor_en(motor_en), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // model update at the rising edge (inputs settle 2 time units after it)
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_cnt = 0; m_last = 0; m_wen = 0;
        end else begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (mot_wr) begin
                if (mot_bit && !m_last) m_cnt = ON;
                m_last = mot_bit;
            end
            if (wen_wr) m_wen = wen_bit;
        end
    end

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (started) begin
            check("R2 motor_en vs model", motor_en, logic'(m_cnt > 0));
            check("R5 ready vs model", ready,
                  logic'(!(ctl_sel && m_wen && !drq && !intrq && m_cnt > 0)));
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic wr_motor(input logic v);
        mot_wr = 1; mot_bit = v; step(); mot_wr = 0;
    endtask

    task automatic wr_wen(input logic v);
        wen_wr = 1; wen_bit = v; step(); wen_wr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        step(3);
        rst_n = 1;
        check("R8 motor off after reset", motor_en, 1'b0);
        check("R8 ready high after reset", ready, 1'b1);

        // R7 arm waits; motor off so bus stays ready (R6)
        ctl_sel = 1;
        wr_wen(1);
        check("R6 ready with motor stopped", ready, 1'b1);

        // R2 pulse length
        wr_motor(1);
        check("R5 wait while motor runs", ready, 1'b0);
        @(negedge clk);
        n = 0;
        while (motor_en) begin n++; @(negedge clk); end
        check("R2 pulse length", logic'(n == ON), 1'b1);
        check("R6 ready released at timeout", ready, 1'b1);
        step();

        // R1 writing 1 again with stored 1 does not trigger
        wr_motor(1);
        check("R1 no trigger when last is 1", motor_en, 1'b0);

        // R1 0 then 1 triggers; R6 drq / intrq / select release same cycle
        wr_motor(0);
        wr_motor(1);
        check("R1 trigger after 0", motor_en, 1'b1);
        drq = 1; #1;
        check("R6 drq releases ready", ready, 1'b1);
        drq = 0; #1;
        check("R5 wait resumes", ready, 1'b0);
        intrq = 1; #1;
        check("R6 intrq releases ready", ready, 1'b1);
        intrq = 0; ctl_sel = 0; #1;
        check("R6 deselect releases ready", ready, 1'b1);
        ctl_sel = 1;
        step(5);

        // R4 a 0 write does not cut the interval; R3 retrigger reloads
        wr_motor(0);
        check("R4 motor still on after 0 write", motor_en, 1'b1);
        wr_motor(1);
        @(negedge clk);
        n = 0;
        while (motor_en) begin n++; @(negedge clk); end
        check("R3 full interval after retrigger", logic'(n == ON), 1'b1);
        step();

        // R7 disable waits
        wr_motor(0);
        wr_motor(1);
        wr_wen(0);
        check("R7 wait disabled gives ready", ready, 1'b1);
        step(3);
        check("R7 wait enable holds 0", ready, 1'b1);
        wr_wen(1);
        check("R7 wait enable back on", ready, 1'b0);

        // R8 reset mid-interval
        rst_n = 0; step(); rst_n = 1;
        check("R8 reset stops motor", motor_en, 1'b0);
        check("R8 reset clears wait enable", ready, 1'b1);
        wr_motor(1);
        check("R8 stored value cleared, 1 triggers", motor_en, 1'b1);
        check("R8 wait enable cleared by reset", ready, 1'b1);
        step(ON + 3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule